// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block is a calendar clock that sits in the eight highest byte addresses of a byte-wide memory space. It counts seconds, minutes, hours, weekday, day of month, month, year and century, all as packed BCD on a 24-hour dial. A one-second tick input drives the count. A host reads and writes the clock through a synchronous port with an address, write data, a write strobe and a combinational read-data bus.

The block keeps two copies of the time. One copy is a set of running counters. The other is a visible copy that the host reads and, while loading, writes. A hold state machine with three states moves data between the copies. In TRACK the visible copy mirrors the counters on every tick. RD_HOLD freezes the visible copy while the counters keep running. WR_HOLD stops the counters so the host can edit the visible copy.

The transitions are as follows. *freeze* takes TRACK to RD_HOLD. *release* takes RD_HOLD to TRACK and copies the counters into the visible copy. *halt* takes TRACK or RD_HOLD to WR_HOLD. *commit* takes WR_HOLD to TRACK and loads the visible copy into the counters. *commit-into-freeze* takes WR_HOLD to RD_HOLD and performs the same load. All of them are triggered by writes to the control byte.

Top module: `cal_clock_top`

## Requirements
- R1: After reset the visible time reads century 00, year 00, month 01, date 01, weekday 01, 00:00:00, and both hold bits read 0.
- R2: Only addresses whose upper bits are all ones form the clock window. The window offsets are: offset 0 for control/century, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year. Any address outside the window reads 0x00, and writes to it change nothing.
- R3: While neither hold bit is set, each tick advances the time by one second. The new value is readable right after the clock edge that samples the tick.
- R4: Seconds and minutes wrap from 59 to 00 with a carry onward. Hours wrap from 23 to 00 and carry into the date.
- R5: The weekday advances once per date change and wraps from 7 to 1.
- R6: The last date is 30 in months 04, 06, 09 and 11, and 31 in the other months except February. February ends at 29 when the binary value of the BCD year is divisible by 4, and at 28 otherwise. After the last date the date becomes 01 and the month advances. Month 12 wraps to 01.
- R7: Year 99 wraps to 00 and increments the century. Century 39 wraps to 00.
- R8: The control byte holds a write-hold bit in bit 7, a read-hold bit in bit 6, and the BCD century in bits 5:0. Writing the byte with bit 7 clear and bit 6 set freezes the visible copy while the counters keep counting. Clearing bit 6 copies the counters into the visible copy on that same edge.
- R9: With bit 7 set, ticks are ignored and the host may write time fields. Clearing bit 7 loads the counters from the visible copy, including any century carried in that same write, and counting resumes from the loaded values.
- R10: Writes to time fields at offsets 1 to 7, and the century bits of a control write, are ignored unless the block is in write hold.
- R11: Stored bits are masked, and masked bits read as 0. The masks are: seconds 0x7F, minutes 0x7F, hours 0x3F, weekday 0x07, date 0x3F, month 0x1F, year 0xFF, century 0x3F.
- R12: A control write with both hold bits set enters write hold. Clearing bit 7 while bit 6 stays set commits the loaded values and enters read hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |

## Verification
The bench builds the block with ADDR_W = 8 and the default century limit of 39. This shrinks the address space to 256 bytes, so every address outside the window can be swept. Because the window tag is a parameter, an 8-bit bus exercises the same decode logic as the full-width space. The bench runs a sweep of 3700 consecutive ticks that crosses minute and hour boundaries, and checks seconds, minutes and hours after each tick. It also checks the end of every month in a non-leap year, a leap year and year 00, as well as the year and century wraps. Every expected value comes from a binary calendar model in the bench.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

    localparam int unsigned REG_CNT = 8;

    typedef enum logic [1:0] {
        ST_TRACK   = 2'd0,
        ST_RD_HOLD = 2'd1,
        ST_WR_HOLD = 2'd2
    } hold_st_e;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_time_t;

    localparam cal_time_t TIME_RESET = '{cent: 8'h00, year: 8'h00, month: 8'h01,
                                         date: 8'h01, day: 8'h01, hour: 8'h00,
                                         min: 8'h00, sec: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_bin(input logic [7:0] v);
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] month, input logic leap);
        case (month)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] fld_mask(input logic [2:0] off);
        case (off)
            3'd0:    return 8'h3F;
            3'd1:    return 8'h7F;
            3'd2:    return 8'h7F;
            3'd3:    return 8'h3F;
            3'd4:    return 8'h07;
            3'd5:    return 8'h3F;
            3'd6:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] fld_get(input cal_time_t t, input logic [2:0] off);
        case (off)
            3'd0:    return t.cent;
            3'd1:    return t.sec;
            3'd2:    return t.min;
            3'd3:    return t.hour;
            3'd4:    return t.day;
            3'd5:    return t.date;
            3'd6:    return t.month;
            default: return t.year;
        endcase
    endfunction

    function automatic cal_time_t fld_set(input cal_time_t t, input logic [2:0] off,
                                          input logic [7:0] v);
        cal_time_t r;
        logic [7:0] m;
        r = t;
        m = v & fld_mask(off);
        case (off)
            3'd0:    r.cent  = m;
            3'd1:    r.sec   = m;
            3'd2:    r.min   = m;
            3'd3:    r.hour  = m;
            3'd4:    r.day   = m;
            3'd5:    r.date  = m;
            3'd6:    r.month = m;
            default: r.year  = m;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_advance.sv
module cal_advance
    import cal_clock_pkg::*;
#(
    parameter logic [7:0] CENT_LAST = 8'h39
) (
    input  cal_time_t cur,
    output cal_time_t nxt
);

    logic       c_min, c_hr, c_day, c_mon, c_yr, c_cent;
    logic       leap;
    logic [7:0] yr_bin;
    logic [7:0] last_date;

    always_comb begin
        yr_bin    = bcd_bin(cur.year);
        leap      = (yr_bin[1:0] == 2'b00);
        last_date = month_last(cur.month, leap);

        c_min  = (cur.sec == 8'h59);
        c_hr   = c_min && (cur.min == 8'h59);
        c_day  = c_hr  && (cur.hour == 8'h23);
        c_mon  = c_day && (cur.date == last_date);
        c_yr   = c_mon && (cur.month == 8'h12);
        c_cent = c_yr  && (cur.year == 8'h99);

        nxt       = cur;
        nxt.sec   = c_min ? 8'h00 : bcd_inc(cur.sec);
        if (c_min)  nxt.min   = c_hr ? 8'h00 : bcd_inc(cur.min);
        if (c_hr)   nxt.hour  = c_day ? 8'h00 : bcd_inc(cur.hour);
        if (c_day)  nxt.day   = (cur.day == 8'h07) ? 8'h01 : cur.day + 8'd1;
        if (c_day)  nxt.date  = c_mon ? 8'h01 : bcd_inc(cur.date);
        if (c_mon)  nxt.month = c_yr ? 8'h01 : bcd_inc(cur.month);
        if (c_yr)   nxt.year  = c_cent ? 8'h00 : bcd_inc(cur.year);
        if (c_cent) nxt.cent  = (cur.cent == CENT_LAST) ? 8'h00 : bcd_inc(cur.cent);
    end

endmodule

// File: rtl/cal_hold_fsm.sv
module cal_hold_fsm
    import cal_clock_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctl_wr,
    input  logic     ctl_wh,
    input  logic     ctl_rh,
    output hold_st_e state_q,
    output logic     load_cnt,
    output logic     refresh_vis
);

    hold_st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK: begin
                if (ctl_wr && ctl_wh)      state_d = ST_WR_HOLD;   // halt
                else if (ctl_wr && ctl_rh) state_d = ST_RD_HOLD;   // freeze
            end
            ST_RD_HOLD: begin
                if (ctl_wr && ctl_wh)       state_d = ST_WR_HOLD;  // halt
                else if (ctl_wr && !ctl_rh) state_d = ST_TRACK;    // release
            end
            ST_WR_HOLD: begin
                if (ctl_wr && !ctl_wh)
                    state_d = ctl_rh ? ST_RD_HOLD : ST_TRACK;      // commit
            end
            default: state_d = ST_TRACK;
        endcase
    end

    always_comb begin
        load_cnt    = (state_q == ST_WR_HOLD) && ctl_wr && !ctl_wh;
        refresh_vis = (state_q == ST_RD_HOLD) && ctl_wr && !ctl_wh && !ctl_rh;
    end

endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
    import cal_clock_pkg::*;
#(
    parameter int unsigned ADDR_W    = 13,
    parameter logic [7:0]  CENT_LAST = 8'h39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int unsigned OFF_W = $clog2(REG_CNT);
    localparam int unsigned TAG_W = ADDR_W - OFF_W;
    localparam logic [TAG_W-1:0] TAG_ALL = {TAG_W{1'b1}};

    logic             in_win;
    logic [OFF_W-1:0] off;
    logic             ctl_wr, fld_wr, tick_go;
    logic             wh_q, rh_q;
    logic             load_cnt, refresh_vis;
    hold_st_e         hold_st;
    cal_time_t        cnt_q, vis_q, cnt_d, vis_d, cnt_adv, vis_wr;

    assign in_win = (addr[ADDR_W-1:OFF_W] == TAG_ALL);
    assign off    = addr[OFF_W-1:0];
    assign ctl_wr = wr_en && in_win && (off == '0);
    assign fld_wr = wr_en && in_win && (off != '0);

    cal_hold_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wh      (wdata[7]),
        .ctl_rh      (wdata[6]),
        .state_q     (hold_st),
        .load_cnt    (load_cnt),
        .refresh_vis (refresh_vis)
    );

    cal_advance #(.CENT_LAST(CENT_LAST)) adv_i (
        .cur (cnt_q),
        .nxt (cnt_adv)
    );

    assign tick_go = tick_1s && (hold_st != ST_WR_HOLD);

    always_comb begin
        vis_wr = vis_q;
        if (hold_st == ST_WR_HOLD && wr_en && in_win)
            vis_wr = fld_set(vis_q, off, wdata);
    end

    always_comb begin
        if (load_cnt)     cnt_d = vis_wr;
        else if (tick_go) cnt_d = cnt_adv;
        else              cnt_d = cnt_q;
    end

    always_comb begin
        if (refresh_vis || hold_st == ST_TRACK) vis_d = cnt_d;
        else if (hold_st == ST_WR_HOLD)         vis_d = vis_wr;
        else                                    vis_d = vis_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= TIME_RESET;
            vis_q <= TIME_RESET;
            wh_q  <= 1'b0;
            rh_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            vis_q <= vis_d;
            if (ctl_wr) begin
                wh_q <= wdata[7];
                rh_q <= wdata[6];
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (in_win) begin
            if (off == '0) rdata = {wh_q, rh_q, vis_q.cent[5:0]};
            else           rdata = fld_get(vis_q, off);
        end
    end

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
    import cal_clock_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick_1s,
    input hold_st_e  hold_st,
    input cal_time_t cnt_q,
    input cal_time_t vis_q,
    input logic      load_cnt,
    input logic      refresh_vis,
    input logic      ctl_wr,
    input logic      fld_wr,
    input logic [7:0] wdata
);

    assert_track_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_st == ST_TRACK) |-> (vis_q == cnt_q));

    assert_rd_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_st == ST_RD_HOLD && !refresh_vis) |=> $stable(vis_q));

    assert_wr_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_st == ST_WR_HOLD && !load_cnt) |=> $stable(cnt_q));

    assert_commit_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (cnt_q == vis_q));

    assert_field_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_wr && hold_st != ST_WR_HOLD && !tick_1s) |=> $stable(vis_q));

    assert_write_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7]) |=> (hold_st == ST_WR_HOLD));

endmodule

bind cal_clock_top cal_clock_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1s     (tick_1s),
    .hold_st     (hold_st),
    .cnt_q       (cnt_q),
    .vis_q       (vis_q),
    .load_cnt    (load_cnt),
    .refresh_vis (refresh_vis),
    .ctl_wr      (ctl_wr),
    .fld_wr      (fld_wr),
    .wdata       (wdata)
);

// File: tb/cal_clock_top_tb_top.sv
`timescale 1ns/1ps
module cal_clock_top_tb_top;

    localparam int AW = 8;
    localparam logic [AW-1:0] WIN = 8'hF8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1s = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_sec, m_min, m_hour, m_day, m_date, m_mon, m_year, m_cent;

    always #2 clk = ~clk;

    cal_clock_top #(.ADDR_W(AW), .CENT_LAST(8'h39)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic m_tick();
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min++; end
        if (m_min == 60) begin m_min = 0; m_hour++; end
        if (m_hour == 24) begin
            m_hour = 0;
            m_day = (m_day == 7) ? 1 : m_day + 1;
            m_date++;
            if (m_date > mdays(m_mon, m_year)) begin
                m_date = 1; m_mon++;
                if (m_mon == 13) begin
                    m_mon = 1; m_year++;
                    if (m_year == 100) begin
                        m_year = 0;
                        m_cent = (m_cent == 39) ? 0 : m_cent + 1;
                    end
                end
            end
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
    endtask

    task automatic set_time(input int c, input int y, input int mo, input int d,
                            input int dw, input int h, input int mi, input int s);
        wr(WIN, 8'h80);
        wr(WIN + 1, bcd(s));
        wr(WIN + 2, bcd(mi));
        wr(WIN + 3, bcd(h));
        wr(WIN + 4, bcd(dw));
        wr(WIN + 5, bcd(d));
        wr(WIN + 6, bcd(mo));
        wr(WIN + 7, bcd(y));
        wr(WIN, bcd(c));
        m_cent = c; m_year = y; m_mon = mo; m_date = d;
        m_day = dw; m_hour = h; m_min = mi; m_sec = s;
    endtask

    task automatic check_time(input string tag);
        logic [7:0] v;
        rd(WIN + 1, v); chk({tag, " sec"},   v, bcd(m_sec));
        rd(WIN + 2, v); chk({tag, " min"},   v, bcd(m_min));
        rd(WIN + 3, v); chk({tag, " hour"},  v, bcd(m_hour));
        rd(WIN + 4, v); chk({tag, " day"},   v, bcd(m_day));
        rd(WIN + 5, v); chk({tag, " date"},  v, bcd(m_date));
        rd(WIN + 6, v); chk({tag, " month"}, v, bcd(m_mon));
        rd(WIN + 7, v); chk({tag, " year"},  v, bcd(m_year));
        rd(WIN, v);     chk({tag, " cent"},  v & 8'h3F, bcd(m_cent));
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        m_cent = 0; m_year = 0; m_mon = 1; m_date = 1; m_day = 1;
        m_hour = 0; m_min = 0; m_sec = 0;
        check_time("R1 reset");
        rd(WIN, v); chk("R1 reset ctl", v, 8'h00);

        // R2 every address outside the window reads zero
        for (int a = 0; a < 248; a++) begin
            rd(AW'(a), v); chk("R2 outside read", v, 8'h00);
        end

        // R11 field masks, loaded in write hold
        wr(WIN, 8'h80);
        for (int o = 1; o < 8; o++) wr(WIN + AW'(o), 8'hFF);
        rd(WIN + 1, v); chk("R11 sec mask", v, 8'h7F);
        rd(WIN + 2, v); chk("R11 min mask", v, 8'h7F);
        rd(WIN + 3, v); chk("R11 hour mask", v, 8'h3F);
        rd(WIN + 4, v); chk("R11 day mask", v, 8'h07);
        rd(WIN + 5, v); chk("R11 date mask", v, 8'h3F);
        rd(WIN + 6, v); chk("R11 month mask", v, 8'h1F);
        rd(WIN + 7, v); chk("R11 year mask", v, 8'hFF);
        wr(WIN, 8'hBF);
        rd(WIN, v); chk("R11 cent mask", v, 8'hBF);

        // R2 writes outside the window are dropped even in write hold
        wr(WIN + 1, 8'h12);
        for (int t = 0; t < 31; t++) wr(AW'((t << 3) | 1), 8'h55);
        rd(WIN + 1, v); chk("R2 outside write", v, 8'h12);

        // R3 R4 sweep of 3700 seconds across minute and hour wraps
        set_time(20, 23, 5, 10, 3, 22, 59, 0);
        check_time("R9 load");
        for (int i = 0; i < 3700; i++) begin
            tick(); m_tick();
            rd(WIN + 1, v); chk("R3 sweep sec", v, bcd(m_sec));
            rd(WIN + 2, v); chk("R4 sweep min", v, bcd(m_min));
            rd(WIN + 3, v); chk("R4 sweep hour", v, bcd(m_hour));
        end
        check_time("R5 after sweep");

        // R6 R5 end of every month, non-leap, leap and year 00
        for (int yi = 0; yi < 3; yi++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                int yr;
                yr = (yi == 0) ? 23 : (yi == 1) ? 24 : 0;
                set_time(20, yr, mo, mdays(mo, yr), (mo % 7) + 1, 23, 59, 59);
                tick(); m_tick();
                check_time("R6 month end");
            end
        end
        // R6 February 28 in a leap year is not the last day
        set_time(20, 24, 2, 28, 7, 23, 59, 59);
        tick(); m_tick();
        check_time("R6 leap feb28");

        // R7 year and century wraps
        set_time(19, 99, 12, 31, 5, 23, 59, 59);
        tick(); m_tick();
        check_time("R7 year wrap");
        set_time(39, 99, 12, 31, 7, 23, 59, 59);
        tick(); m_tick();
        check_time("R7 century wrap");

        // R8 read hold
        set_time(20, 25, 3, 14, 2, 10, 20, 30);
        wr(WIN, 8'h40);
        rd(WIN, v); chk("R8 ctl rh", v, 8'h40 | bcd(20));
        for (int i = 0; i < 5; i++) begin tick(); m_tick(); end
        rd(WIN + 1, v); chk("R8 frozen sec", v, 8'h30);
        wr(WIN, 8'h00);
        check_time("R8 release refresh");

        // R10 time writes outside write hold are ignored
        wr(WIN + 1, 8'h07);
        wr(WIN + 3, 8'h05);
        wr(WIN, 8'h11);
        check_time("R10 ignored");

        // R9 write hold stalls ticks, commit resumes from loaded value
        wr(WIN, 8'h80 | bcd(20));
        for (int i = 0; i < 3; i++) tick();
        rd(WIN + 1, v); chk("R9 stalled sec", v, bcd(m_sec));
        wr(WIN + 1, 8'h10);
        wr(WIN, 8'h00 | bcd(21));
        m_sec = 10; m_cent = 21;
        check_time("R9 commit");
        tick(); m_tick();
        check_time("R9 resume");

        // R12 both bits set: write hold wins, commit into read hold
        wr(WIN, 8'hC0);
        rd(WIN, v); chk("R12 ctl both", v, 8'hC0 | bcd(m_cent));
        tick();
        rd(WIN + 1, v); chk("R12 stalled", v, bcd(m_sec));
        wr(WIN + 1, 8'h05);
        wr(WIN, 8'h40 | bcd(m_cent));
        m_sec = 5;
        rd(WIN, v); chk("R12 into read hold", v, 8'h40 | bcd(m_cent));
        tick(); m_tick();
        tick(); m_tick();
        rd(WIN + 1, v); chk("R12 frozen", v, 8'h05);
        wr(WIN, 8'h00);
        check_time("R12 release");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule